// File: doc/BRIEF.md
# Two-Dimensional Six-Tap Half-Pel Upsampler

This block produces half-pixel interpolated samples around a 4x4 block of integer pixels, using a separable six-tap filter. Integer pixels arrive one per accepted cycle in raster order: ten rows of ten pixels. This 10x10 window starts three pixels above and to the left of the block. A row stage holds the last six pixels of the current row in a shift register. All six are summed in one cycle by a fused weighted adder. Each unclipped row sum, together with the integer pixel that sits at the matching column, is pushed into a per-column shift register. One vertical filter pair per column then reads all six entries of that column at once.

For every output position the block emits three samples, each tagged with a column and row index 0..4:
- `h_o`: the horizontal half-pel sample at (x-0.5, y).
- `v_o`: the vertical half-pel sample at (x, y-0.5).
- `c_o`: the centre sample at (x-0.5, y-0.5).

Here x and y are the tag values in block coordinates. A start pulse begins a new block. Every block runs through the same loop.

Top module: `hpel_upsampler`

## Requirements
- R1: After reset, `valid_o` is low and stays low until the first output is due.
- R2: `h_o` = clip((p[-2] - 5p[-1] + 20p[0] + 20p[1] - 5p[2] + p[3] + 16) >> 5) to 0..255. The taps run along one window row, with the window pixels at columns col..col+5 and row row+3.
- R3: `v_o` applies the same taps, rounding and clip down one window column. It uses column col+3 and rows row..row+5.
- R4: `c_o` applies the taps to the six unclipped row sums taken from window rows row..row+5, each over columns col..col+5. The result is rounded by +512, shifted right by 10 and clipped to 0..255.
- R5: The pixel accepted at window row r and column c, with both r >= 5 and c >= 5, yields exactly one output tagged col = c-5 and row = r-5. Outputs appear in raster order.
- R6: `valid_o` rises exactly two clock edges after the edge that accepts the triggering pixel. Cycles with `valid_i` low advance nothing and create no output.
- R7: `start_i` resets the pixel position to row 0, column 0 and abandons any partial block. If `valid_i` is high in the same cycle, that pixel is the first pixel of the new block. A start without a pixel makes the next accepted pixel the first one.
- R8: After 100 pixels of a block have been accepted, further pixels are ignored until the next `start_i`. They produce no output.
- R9: A start on the cycle right after a block's last pixel leaves that block's pending outputs intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a new block |
| valid_i | input | 1 | `pix_i` holds a pixel this cycle |
| pix_i | input | 8 | Integer pixel, raster order within the 10x10 window |
| valid_o | output | 1 | Output samples and tags are valid |
| col_o | output | 3 | Output column tag, 0..4 |
| row_o | output | 3 | Output row tag, 0..4 |
| h_o | output | 8 | Horizontal half-pel sample |
| v_o | output | 8 | Vertical half-pel sample |
| c_o | output | 8 | Centre half-pel sample |

## Verification
Stripe, checkerboard and saturated blocks drive the row sums to both signs and past the pixel range. A design that clipped the row sums before the vertical pass would give the wrong centre value, and one with a wrong rounding offset or shift would be off by one or saturate. Gapped input streams catch a design that advances its shift registers or counters on idle cycles, which would shift the tags or mix in stale pixels. Aborted blocks, starts without a pixel, starts right after a block's last pixel, and surplus pixels after a full block probe the start and overflow handling. Getting these wrong would restart on the wrong pixel, drop pending results, or let surplus pixels wrap into a phantom block.

// File: rtl/hpel_pkg.sv
package hpel_pkg;
  localparam int unsigned PIX_W  = 8;
  localparam int unsigned TAPS   = 6;
  localparam int unsigned HS_W   = PIX_W + 7;   // unclipped row sum
  localparam int unsigned VS_W   = HS_W + 6;    // centre sum over row sums
  localparam int unsigned ROW_SH = 5;
  localparam int unsigned CTR_SH = 10;
  localparam int          PIX_MAX = (1 << PIX_W) - 1;

  typedef logic [PIX_W-1:0]       pix_t;
  typedef logic signed [HS_W-1:0] hsum_t;

  function automatic pix_t round_clip(input logic signed [31:0] val, input int unsigned sh);
    logic signed [31:0] r;
    r = (val + (32'sd1 <<< (sh - 1))) >>> sh;
    if (r < 32'sd0) return '0;
    if (r > PIX_MAX) return pix_t'(PIX_MAX);
    return pix_t'(r);
  endfunction
endpackage

// File: rtl/hpel_tap6.sv
module hpel_tap6 import hpel_pkg::*; #(
  parameter int unsigned IN_W  = PIX_W + 1,
  parameter int unsigned OUT_W = IN_W + 6
) (
  input  logic signed [IN_W-1:0]  tap_i [TAPS],
  output logic signed [OUT_W-1:0] sum_o
);
  logic signed [OUT_W-1:0] ext [TAPS];
  logic signed [OUT_W-1:0] outer, inner, mid;

  // weights 1,-5,20,20,-5,1 folded by symmetry into shift-add terms
  always_comb begin
    for (int k = 0; k < TAPS; k++) ext[k] = OUT_W'(tap_i[k]);
    outer = ext[0] + ext[5];
    inner = ext[1] + ext[4];
    mid   = ext[2] + ext[3];
    sum_o = outer - ((inner <<< 2) + inner) + ((mid <<< 4) + (mid <<< 2));
  end
endmodule

// File: rtl/hpel_row_stage.sv
module hpel_row_stage import hpel_pkg::*; #(
  parameter  int unsigned BLK  = 4,
  localparam int unsigned WIN  = BLK + TAPS,
  localparam int unsigned NCOL = WIN - TAPS + 1,
  localparam int unsigned CW   = $clog2(WIN),
  localparam int unsigned OCW  = $clog2(NCOL)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic           valid_i,
  input  pix_t           pix_i,
  output logic           a_vld_o,
  output logic           a_start_o,
  output logic [OCW-1:0] a_col_o,
  output logic [CW-1:0]  a_row_o,
  output hsum_t          hsum_o,
  output pix_t           mid_pix_o
);
  pix_t sr [TAPS];
  pix_t nxt_sr [TAPS];
  logic signed [PIX_W:0] sr_ext [TAPS];
  logic [CW-1:0] col_q, row_q, cur_col, cur_row, nxt_col, nxt_row;
  logic done_q, nxt_done, take;

  always_comb begin
    cur_col  = start_i ? '0 : col_q;
    cur_row  = start_i ? '0 : row_q;
    take     = valid_i && (start_i || !done_q);
    nxt_col  = cur_col;
    nxt_row  = cur_row;
    nxt_done = start_i ? 1'b0 : done_q;
    for (int k = 0; k < TAPS; k++) nxt_sr[k] = start_i ? '0 : sr[k];
    if (take) begin
      for (int k = 0; k < TAPS - 1; k++) nxt_sr[k] = start_i ? '0 : sr[k+1];
      nxt_sr[TAPS-1] = pix_i;
      if (cur_col == CW'(WIN - 1)) begin
        nxt_col = '0;
        if (cur_row == CW'(WIN - 1)) begin
          nxt_row  = '0;
          nxt_done = 1'b1;
        end else begin
          nxt_row = cur_row + 1'b1;
        end
      end else begin
        nxt_col = cur_col + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr        <= '{default: '0};
      col_q     <= '0;
      row_q     <= '0;
      done_q    <= 1'b0;
      a_vld_o   <= 1'b0;
      a_start_o <= 1'b0;
      a_col_o   <= '0;
      a_row_o   <= '0;
    end else begin
      sr        <= nxt_sr;
      col_q     <= nxt_col;
      row_q     <= nxt_row;
      done_q    <= nxt_done;
      a_start_o <= start_i;
      a_vld_o   <= take && (cur_col >= CW'(TAPS - 1));
      a_col_o   <= OCW'(cur_col - CW'(TAPS - 1));
      a_row_o   <= cur_row;
    end
  end

  always_comb
    for (int k = 0; k < TAPS; k++) sr_ext[k] = signed'({1'b0, sr[k]});

  hpel_tap6 #(.IN_W(PIX_W + 1), .OUT_W(HS_W)) u_row_tap (
    .tap_i (sr_ext),
    .sum_o (hsum_o)
  );

  assign mid_pix_o = sr[TAPS/2];
endmodule

// File: rtl/hpel_col_bank.sv
module hpel_col_bank import hpel_pkg::*; #(
  parameter  int unsigned BLK  = 4,
  localparam int unsigned WIN  = BLK + TAPS,
  localparam int unsigned NCOL = WIN - TAPS + 1,
  localparam int unsigned CW   = $clog2(WIN),
  localparam int unsigned OCW  = $clog2(NCOL)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           flush_i,
  input  logic           push_i,
  input  logic [OCW-1:0] push_col_i,
  input  logic [CW-1:0]  push_row_i,
  input  hsum_t          hsum_i,
  input  pix_t           pix_i,
  output logic           b_vld_o,
  output logic [OCW-1:0] b_col_o,
  output logic [OCW-1:0] b_row_o,
  output pix_t           h_sel_o,
  output pix_t           v_sel_o,
  output pix_t           c_sel_o
);
  pix_t h_val [NCOL];
  pix_t v_val [NCOL];
  pix_t c_val [NCOL];

  for (genvar j = 0; j < NCOL; j++) begin : g_col
    hsum_t hcol [TAPS];
    pix_t  pcol [TAPS];
    logic signed [PIX_W:0]  pcol_ext [TAPS];
    logic signed [HS_W+5:0] vsum;
    logic signed [VS_W-1:0] csum;
    logic sel;

    assign sel = push_i && (push_col_i == OCW'(j));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        hcol <= '{default: '0};
        pcol <= '{default: '0};
      end else if (flush_i) begin
        hcol <= '{default: '0};
        pcol <= '{default: '0};
      end else if (sel) begin
        for (int k = 0; k < TAPS - 1; k++) begin
          hcol[k] <= hcol[k+1];
          pcol[k] <= pcol[k+1];
        end
        hcol[TAPS-1] <= hsum_i;
        pcol[TAPS-1] <= pix_i;
      end
    end

    always_comb
      for (int k = 0; k < TAPS; k++) pcol_ext[k] = signed'({1'b0, pcol[k]});

    hpel_tap6 #(.IN_W(PIX_W + 1), .OUT_W(HS_W + 6)) u_vert_tap (
      .tap_i (pcol_ext),
      .sum_o (vsum)
    );

    hpel_tap6 #(.IN_W(HS_W), .OUT_W(VS_W)) u_ctr_tap (
      .tap_i (hcol),
      .sum_o (csum)
    );

    assign h_val[j] = round_clip(32'(hcol[TAPS/2]), ROW_SH);
    assign v_val[j] = round_clip(32'(vsum), ROW_SH);
    assign c_val[j] = round_clip(32'(csum), CTR_SH);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      b_vld_o <= 1'b0;
      b_col_o <= '0;
      b_row_o <= '0;
    end else begin
      b_vld_o <= push_i && (push_row_i >= CW'(TAPS - 1));
      b_col_o <= push_col_i;
      b_row_o <= OCW'(push_row_i - CW'(TAPS - 1));
    end
  end

  always_comb begin
    h_sel_o = '0;
    v_sel_o = '0;
    c_sel_o = '0;
    for (int j = 0; j < NCOL; j++) begin
      if (b_col_o == OCW'(j)) begin
        h_sel_o = h_val[j];
        v_sel_o = v_val[j];
        c_sel_o = c_val[j];
      end
    end
  end
endmodule

// File: rtl/hpel_upsampler.sv
module hpel_upsampler import hpel_pkg::*; #(
  parameter  int unsigned BLK  = 4,
  localparam int unsigned WIN  = BLK + TAPS,
  localparam int unsigned NCOL = WIN - TAPS + 1,
  localparam int unsigned CW   = $clog2(WIN),
  localparam int unsigned OCW  = $clog2(NCOL)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             valid_i,
  input  logic [PIX_W-1:0] pix_i,
  output logic             valid_o,
  output logic [OCW-1:0]   col_o,
  output logic [OCW-1:0]   row_o,
  output logic [PIX_W-1:0] h_o,
  output logic [PIX_W-1:0] v_o,
  output logic [PIX_W-1:0] c_o
);
  logic           a_vld, a_start, b_vld;
  logic [OCW-1:0] a_col, b_col, b_row;
  logic [CW-1:0]  a_row;
  hsum_t          hsum;
  pix_t           mid_pix, h_sel, v_sel, c_sel;

  hpel_row_stage #(.BLK(BLK)) u_row (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .valid_i   (valid_i),
    .pix_i     (pix_i),
    .a_vld_o   (a_vld),
    .a_start_o (a_start),
    .a_col_o   (a_col),
    .a_row_o   (a_row),
    .hsum_o    (hsum),
    .mid_pix_o (mid_pix)
  );

  // column flush follows start by one edge so a pending row push is not lost
  hpel_col_bank #(.BLK(BLK)) u_cols (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .flush_i    (a_start),
    .push_i     (a_vld),
    .push_col_i (a_col),
    .push_row_i (a_row),
    .hsum_i     (hsum),
    .pix_i      (mid_pix),
    .b_vld_o    (b_vld),
    .b_col_o    (b_col),
    .b_row_o    (b_row),
    .h_sel_o    (h_sel),
    .v_sel_o    (v_sel),
    .c_sel_o    (c_sel)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      col_o   <= '0;
      row_o   <= '0;
      h_o     <= '0;
      v_o     <= '0;
      c_o     <= '0;
    end else begin
      valid_o <= b_vld;
      if (b_vld) begin
        col_o <= b_col;
        row_o <= b_row;
        h_o   <= h_sel;
        v_o   <= v_sel;
        c_o   <= c_sel;
      end
    end
  end
endmodule

// File: rtl/hpel_upsampler_chk.sv
module hpel_upsampler_chk #(
  parameter  int unsigned BLK   = 4,
  localparam int unsigned WIN   = BLK + 6,
  localparam int unsigned NCOL  = BLK + 1,
  localparam int unsigned OCW   = $clog2(NCOL),
  localparam int unsigned TOTAL = WIN * WIN
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           start_i,
  input logic           valid_i,
  input logic           valid_o,
  input logic [OCW-1:0] col_o,
  input logic [OCW-1:0] row_o
);
  int unsigned    n_acc;
  logic [OCW-1:0] last_col;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      n_acc    <= 0;
      last_col <= '0;
    end else begin
      if (start_i) n_acc <= valid_i ? 1 : 0;
      else if (valid_i && n_acc < TOTAL) n_acc <= n_acc + 1;
      if (valid_o) last_col <= col_o;
    end
  end

  assert_out_follows_pixel_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(valid_i, 3));

  assert_tag_range_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (col_o < OCW'(NCOL)) && (row_o < OCW'(NCOL)));

  assert_col_order_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && col_o != '0) |-> col_o == OCW'(last_col + 1'b1));

  assert_overflow_ignored_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !start_i && n_acc >= TOTAL) |-> ##3 !valid_o);
endmodule

bind hpel_upsampler hpel_upsampler_chk #(.BLK(BLK)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_i (start_i),
  .valid_i (valid_i),
  .valid_o (valid_o),
  .col_o   (col_o),
  .row_o   (row_o)
);

// File: tb/hpel_upsampler_test.sv
module hpel_upsampler_test;
  logic clk = 1'b0, rst_ni = 1'b0, start_i = 1'b0, valid_i = 1'b0;
  logic [7:0] pix_i = '0;
  logic valid_o;
  logic [2:0] col_o, row_o;
  logic [7:0] h_o, v_o, c_o;

  hpel_upsampler uut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .valid_i(valid_i), .pix_i(pix_i),
    .valid_o(valid_o), .col_o(col_o), .row_o(row_o), .h_o(h_o), .v_o(v_o), .c_o(c_o)
  );

  always #2 clk = ~clk;

  typedef struct { int due; int col; int row; int h; int v; int c; } exp_t;
  exp_t q[$];
  int checks = 0, errors = 0, cyc = 0;
  int m_col = 0, m_row = 0;
  bit m_done = 0, chk_on = 0;
  int win [10][10];
  int unsigned seed = 32'h1234_5678;
  string phase = "reset";

  always @(posedge clk) cyc++;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s [%s] cyc=%0d actual=%0d expected=%0d", req, phase, cyc, act, expv);
    end
  endtask

  function automatic int f6(int a, int b, int c, int d, int e, int f);
    return a - 5*b + 20*c + 20*d - 5*e + f;
  endfunction

  function automatic int rclip(int x, int sh);
    int r = (x + (1 << (sh - 1))) >>> sh;
    return r < 0 ? 0 : (r > 255 ? 255 : r);
  endfunction

  function automatic int rnd();
    seed = seed * 1664525 + 1013904223;
    return int'(seed >> 8);
  endfunction

  function automatic exp_t expect_at(int j, int i);
    exp_t e;
    int hs [6];
    for (int k = 0; k < 6; k++)
      hs[k] = f6(win[i+k][j], win[i+k][j+1], win[i+k][j+2], win[i+k][j+3], win[i+k][j+4], win[i+k][j+5]);
    e.col = j; e.row = i;
    e.h = rclip(hs[3], 5);
    e.v = rclip(f6(win[i][j+3], win[i+1][j+3], win[i+2][j+3], win[i+3][j+3], win[i+4][j+3], win[i+5][j+3]), 5);
    e.c = rclip(f6(hs[0], hs[1], hs[2], hs[3], hs[4], hs[5]), 10);
    e.due = 0;
    return e;
  endfunction

  task automatic drive(input bit v, input bit s, input int p);
    exp_t e;
    @(negedge clk);
    valid_i = v; start_i = s; pix_i = 8'(p);
    if (s) begin m_col = 0; m_row = 0; m_done = 0; end
    if (v && !m_done) begin
      win[m_row][m_col] = p;
      if (m_row >= 5 && m_col >= 5) begin
        e = expect_at(m_col - 5, m_row - 5);
        e.due = cyc + 3;
        q.push_back(e);
      end
      if (m_col == 9) begin
        m_col = 0;
        if (m_row == 9) begin m_row = 0; m_done = 1; end else m_row++;
      end else m_col++;
    end
  endtask

  function automatic int gen(int mode, int n);
    case (mode)
      1: return (((n / 10) + (n % 10)) % 2 != 0) ? 255 : 0;
      2: return 255;
      3: return (n * 7 + 3) & 255;
      4: return ((n % 10) % 2 != 0) ? 255 : 0;
      default: return rnd() & 255;
    endcase
  endfunction

  task automatic feed(input int mode, input bit gaps, input bit start_first, input int npix);
    for (int n = 0; n < npix; n++) begin
      drive(1'b1, start_first && n == 0, gen(mode, n));
      if (gaps && (rnd() % 3 == 0)) repeat (rnd() % 3 + 1) drive(1'b0, 1'b0, 0);
    end
  endtask

  task automatic settle(input string req);
    repeat (6) drive(1'b0, 1'b0, 0);
    chk(q.size() == 0, req, q.size(), 0);
  endtask

  // per-cycle comparison against the behavioural model
  always @(negedge clk) begin
    exp_t e;
    if (chk_on) begin
      if (q.size() > 0 && q[0].due == cyc) begin
        e = q.pop_front();
        chk(valid_o == 1'b1, "R6", int'(valid_o), 1);
        chk(int'(col_o) == e.col, "R5", int'(col_o), e.col);
        chk(int'(row_o) == e.row, "R5", int'(row_o), e.row);
        chk(int'(h_o) == e.h, "R2", int'(h_o), e.h);
        chk(int'(v_o) == e.v, "R3", int'(v_o), e.v);
        chk(int'(c_o) == e.c, "R4", int'(c_o), e.c);
      end else begin
        chk(valid_o == 1'b0, "R6", int'(valid_o), 0);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 200000);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    chk_on = 1;
    repeat (4) @(negedge clk);
    chk(valid_o == 1'b0, "R1", int'(valid_o), 0);
    rst_ni = 1'b1;
    repeat (3) drive(1'b0, 1'b0, 0);
    chk(valid_o == 1'b0, "R1", int'(valid_o), 0);

    phase = "R2 R3 R4 random";     feed(0, 0, 1, 100); settle("R5");
    phase = "R6 gapped checker";   feed(1, 1, 1, 100); settle("R6");
    phase = "R4 column stripes";   feed(4, 0, 1, 100); settle("R4");
    phase = "R2 saturated gapped"; feed(2, 1, 1, 100); settle("R2");
    phase = "R7 start alone";      drive(1'b0, 1'b1, 0); drive(1'b0, 1'b0, 0);
                                   feed(3, 0, 0, 100); settle("R7");
    phase = "R7 abort early";      feed(0, 0, 1, 37); feed(0, 1, 1, 100); settle("R7");
    phase = "R7 abort in output";  feed(0, 0, 1, 63); feed(0, 0, 1, 100); settle("R7");
    phase = "R8 surplus pixels";   feed(0, 0, 1, 100); feed(0, 1, 0, 60); settle("R8");
    phase = "R9 back to back";     feed(0, 0, 1, 100); feed(1, 0, 1, 100); feed(0, 0, 1, 100);
                                   settle("R9");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule